// File: doc/BRIEF.md
# Two-Vector Delay Test Strobe Sequencer

This block drives one two-vector delay test of a combinational region that sits between a bank of input latches and a bank of output latches. A single fast base clock paces it. After a start pulse it presents the first vector and pulses the input-latch strobe. It then waits a long, programmable settling interval so that the first vector settles fully. Next it presents the second vector and pulses the input-latch strobe again. Exactly one rated period after that second launch it pulses the output-latch strobe, and it then records the response word and raises a done flag.

The rated period and the slow period are given at runtime as counts of base-clock cycles. The slow period must be longer than the rated period. The block only produces the strobes and moves words: it does not create vectors, judge responses, or model the region under test.

Top module: `delay_pair_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it, `in_strobe`, `out_strobe`, `done` and `cfg_err` are 0, and `in_word` and `resp_word` are all zeros.
- R2: `cfg_err` is 1 on the cycle after one where `rated_cyc` is 0 or `slow_cyc` is less than or equal to `rated_cyc`, and 0 otherwise. A start pulse given while that condition holds is ignored.
- R3: When start is accepted at a clock edge, `in_strobe` is high for the single cycle that follows, and during that cycle `in_word` shows the `vec_a` value sampled at the start edge.
- R4: The second `in_strobe` pulse comes exactly `slow_cyc` cycles after the first and lasts one cycle. From that pulse on, `in_word` shows the `vec_b` value sampled at start. Between the two pulses `in_word` keeps the first vector.
- R5: `out_strobe` is high for one cycle, exactly `rated_cyc` cycles after the second `in_strobe` pulse. This holds for every `rated_cyc` of 1 or more.
- R6: At the clock edge that ends the `out_strobe` cycle, `resp_word` takes the value of `resp_in`, and `done` rises at that same edge.
- R7: `resp_word` and `done` stay unchanged until the next accepted start. `done` falls at the accepted start edge.
- R8: A start pulse given while a test is running is ignored. Changes to `vec_a`, `vec_b`, `rated_cyc` or `slow_cyc` after the start edge have no effect on that test.
- R9: `in_strobe` and `out_strobe` are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a test when the block is idle and the configuration is valid |
| rated_cyc | input | CNT_W | Launch-to-capture gap, in base cycles |
| slow_cyc | input | CNT_W | Spacing between the two launches, in base cycles |
| vec_a | input | DATA_W | First vector |
| vec_b | input | DATA_W | Second vector |
| resp_in | input | RESP_W | Response from the region under test |
| in_word | output | DATA_W | Word presented to the input latches |
| in_strobe | output | 1 | Input-latch enable pulse |
| out_strobe | output | 1 | Output-latch enable pulse |
| resp_word | output | RESP_W | Captured response |
| done | output | 1 | Response captured; held until the next start |
| cfg_err | output | 1 | Rated/slow setting is invalid |

## Verification
Count cycles from the start edge, with cycle 1 the cycle that follows it. The first launch falls in cycle 1 and the second in cycle 1+S. The capture strobe falls in cycle 1+S+R, and `done` with the new `resp_word` appears in cycle 2+S+R. `cfg_err` follows its inputs one cycle late. The bench drives inputs and samples outputs on falling edges and compares every output against this schedule on every cycle of each test. `resp_in` changes on every cycle to a value that depends on the cycle number, so a capture one cycle early or late gives a wrong word. Start pokes and configuration changes during a test, resets in the middle of a run, and a hold period after done are checked against the same schedule.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD_V1,
    ST_SETTLE,
    ST_LOAD_V2,
    ST_WAIT_R,
    ST_CAPTURE,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/dps_cfg_guard.sv
module dps_cfg_guard #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rated,
  input  logic [CNT_W-1:0] slow,
  output logic             bad_now,
  output logic             cfg_err
);
  always_comb bad_now = (rated == '0) || (slow <= rated);

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= bad_now;
  end
endmodule

// File: rtl/dps_interval.sv
module dps_interval #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - CNT_W'(1);
  end

  always_comb expired = (cnt == '0);

  // R5
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && expired) |=> expired);
endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             bad_now,
  input  logic [CNT_W-1:0] rated,
  input  logic [CNT_W-1:0] slow,
  input  logic             timer_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             go_v2,
  output logic             cap_now,
  output logic             in_strobe,
  output logic             out_strobe
);
  seq_state_t       state, nxt;
  logic [CNT_W-1:0] rated_q, slow_q;

  always_comb accept = (state == ST_IDLE) && start && !bad_now;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    go_v2    = 1'b0;
    unique case (state)
      ST_IDLE:    if (accept) nxt = ST_LOAD_V1;
      ST_LOAD_V1: begin
        nxt      = ST_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = slow_q - CNT_W'(2);
      end
      ST_SETTLE:  if (timer_zero) begin
        nxt   = ST_LOAD_V2;
        go_v2 = 1'b1;
      end
      ST_LOAD_V2: begin
        if (rated_q == CNT_W'(1)) nxt = ST_CAPTURE;
        else begin
          nxt      = ST_WAIT_R;
          tmr_load = 1'b1;
          tmr_val  = rated_q - CNT_W'(2);
        end
      end
      ST_WAIT_R:  if (timer_zero) nxt = ST_CAPTURE;
      ST_CAPTURE: nxt = ST_DONE;
      ST_DONE:    nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_comb cap_now = (state == ST_CAPTURE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      rated_q    <= '0;
      slow_q     <= '0;
      in_strobe  <= 1'b0;
      out_strobe <= 1'b0;
    end else begin
      state      <= nxt;
      in_strobe  <= (nxt == ST_LOAD_V1) || (nxt == ST_LOAD_V2);
      out_strobe <= (nxt == ST_CAPTURE);
      if (accept) begin
        rated_q <= rated;
        slow_q  <= slow;
      end
    end
  end

  // Cycle distances between strobes, used by the checks below
  logic [CNT_W-1:0] v1_gap, v2_gap;
  always_ff @(posedge clk) begin
    if (rst) begin
      v1_gap <= '0;
      v2_gap <= '0;
    end else begin
      if (state == ST_LOAD_V1)  v1_gap <= CNT_W'(1);
      else if (v1_gap != '1)    v1_gap <= v1_gap + CNT_W'(1);
      if (state == ST_LOAD_V2)  v2_gap <= CNT_W'(1);
      else if (v2_gap != '1)    v2_gap <= v2_gap + CNT_W'(1);
    end
  end

  // R4
  settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_strobe && state == ST_LOAD_V2) |-> (v1_gap == slow_q));
  // R5
  rated_gap_chk: assert property (@(posedge clk) disable iff (rst)
    out_strobe |-> (v2_gap == rated_q));
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_strobe && out_strobe));
  // R9
  in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    in_strobe |=> !in_strobe);
  // R9
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_strobe |=> !out_strobe);
endmodule

// File: rtl/dps_capture.sv
module dps_capture #(
  parameter int RESP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_now,
  input  logic              clear,
  input  logic [RESP_W-1:0] resp_in,
  output logic [RESP_W-1:0] resp_word,
  output logic              done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_word <= '0;
      done      <= 1'b0;
    end else begin
      if (cap_now) resp_word <= resp_in;
      if (cap_now)    done <= 1'b1;
      else if (clear) done <= 1'b0;
    end
  end

  // R7
  resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !clear) |=> ($stable(resp_word) && done));
  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(cap_now));
endmodule

// File: rtl/delay_pair_sequencer.sv
module delay_pair_sequencer #(
  parameter int DATA_W = 16,
  parameter int RESP_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  rated_cyc,
  input  logic [CNT_W-1:0]  slow_cyc,
  input  logic [DATA_W-1:0] vec_a,
  input  logic [DATA_W-1:0] vec_b,
  input  logic [RESP_W-1:0] resp_in,
  output logic [DATA_W-1:0] in_word,
  output logic              in_strobe,
  output logic              out_strobe,
  output logic [RESP_W-1:0] resp_word,
  output logic              done,
  output logic              cfg_err
);
  logic             bad_now, timer_zero, tmr_load, accept, go_v2, cap_now;
  logic [CNT_W-1:0] tmr_val;
  logic [DATA_W-1:0] v2_q;

  dps_cfg_guard #(.CNT_W(CNT_W)) u_guard (
    .clk(clk), .rst(rst), .rated(rated_cyc), .slow(slow_cyc),
    .bad_now(bad_now), .cfg_err(cfg_err)
  );

  dps_interval #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .expired(timer_zero)
  );

  dps_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .bad_now(bad_now),
    .rated(rated_cyc), .slow(slow_cyc), .timer_zero(timer_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .accept(accept),
    .go_v2(go_v2), .cap_now(cap_now),
    .in_strobe(in_strobe), .out_strobe(out_strobe)
  );

  dps_capture #(.RESP_W(RESP_W)) u_cap (
    .clk(clk), .rst(rst), .cap_now(cap_now), .clear(accept),
    .resp_in(resp_in), .resp_word(resp_word), .done(done)
  );

  // Vector path: first vector on accept, second at the second launch
  always_ff @(posedge clk) begin
    if (rst) begin
      in_word <= '0;
      v2_q    <= '0;
    end else if (accept) begin
      in_word <= vec_a;
      v2_q    <= vec_b;
    end else if (go_v2) begin
      in_word <= v2_q;
    end
  end

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!accept && !go_v2) |=> $stable(in_word));
endmodule

// File: tb/tb_delay_pair_sequencer.sv
module tb_delay_pair_sequencer;
  localparam int DW = 16;
  localparam int RW = 16;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [CW-1:0] rated_cyc = '0;
  logic [CW-1:0] slow_cyc = '0;
  logic [DW-1:0] vec_a = '0;
  logic [DW-1:0] vec_b = '0;
  logic [RW-1:0] resp_in = '0;
  logic [DW-1:0] in_word;
  logic          in_strobe, out_strobe, done, cfg_err;
  logic [RW-1:0] resp_word;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  delay_pair_sequencer #(.DATA_W(DW), .RESP_W(RW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .start(start), .rated_cyc(rated_cyc),
    .slow_cyc(slow_cyc), .vec_a(vec_a), .vec_b(vec_b), .resp_in(resp_in),
    .in_word(in_word), .in_strobe(in_strobe), .out_strobe(out_strobe),
    .resp_word(resp_word), .done(done), .cfg_err(cfg_err)
  );

  function automatic logic [RW-1:0] rsig(int c);
    return RW'((c * 40503) ^ 23130);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_test(input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input int r, input int s, input bit poke, input int off);
    logic [RW-1:0] held;
    @(negedge clk);
    vec_a = a; vec_b = b; rated_cyc = CW'(r); slow_cyc = CW'(s);
    start = 1'b1; resp_in = rsig(off);
    for (int c = 1; c <= s + r + 3; c++) begin
      @(negedge clk);
      if (c == 1) start = 1'b0;
      if (poke && c == 3) begin
        start = 1'b1; vec_a = ~a; vec_b = ~b;
        rated_cyc = CW'(r + 2); slow_cyc = CW'(s + 5);
      end
      if (poke && c == 4) start = 1'b0;
      resp_in = rsig(c + off);
      // R3 R4 launch strobes
      chk(in_strobe == ((c == 1) || (c == 1 + s)), "R3/R4 in_strobe", in_strobe, (c == 1) || (c == 1 + s));
      // R5 capture strobe
      chk(out_strobe == (c == 1 + s + r), "R5 out_strobe", out_strobe, c == 1 + s + r);
      // R4 word presented
      chk(in_word == ((c >= 1 + s) ? b : a), "R4 in_word", in_word, (c >= 1 + s) ? b : a);
      // R6 R7 done timing
      chk(done == (c >= 2 + s + r), "R6/R7 done", done, c >= 2 + s + r);
      // R9
      chk(!(in_strobe && out_strobe), "R9 exclusive", {in_strobe, out_strobe}, 0);
    end
    // R6 captured word
    chk(resp_word == rsig(1 + s + r + off), "R6 resp_word", resp_word, rsig(1 + s + r + off));
    held = resp_word;
    vec_a = a; vec_b = b; rated_cyc = CW'(r); slow_cyc = CW'(s);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      resp_in = RW'($urandom);
      // R7 hold after capture
      chk(resp_word == held && done, "R7 hold", resp_word, held);
      // R8 no spurious strobe after the run
      chk(!in_strobe && !out_strobe, "R8 quiet", {in_strobe, out_strobe}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!in_strobe && !out_strobe && !done && !cfg_err, "R1 flags", {in_strobe, out_strobe, done, cfg_err}, 0);
    chk(in_word == '0 && resp_word == '0, "R1 words", {in_word, resp_word}, 0);
    rated_cyc = 12'd3; slow_cyc = 12'd8;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!cfg_err && !done && !in_strobe, "R1 after release", {cfg_err, done, in_strobe}, 0);

    // R2 invalid configurations
    rated_cyc = 12'd4; slow_cyc = 12'd4; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(cfg_err, "R2 equal periods", cfg_err, 1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!in_strobe && !out_strobe, "R2 start ignored", {in_strobe, out_strobe}, 0);
    end
    rated_cyc = 12'd0; slow_cyc = 12'd5; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(cfg_err, "R2 zero rated", cfg_err, 1);
    @(negedge clk);
    chk(!in_strobe, "R2 zero rated ignored", in_strobe, 0);
    rated_cyc = 12'd6; slow_cyc = 12'd2;
    @(negedge clk);
    chk(cfg_err, "R2 slow below rated", cfg_err, 1);
    rated_cyc = 12'd2; slow_cyc = 12'd3;
    @(negedge clk);
    chk(!cfg_err, "R2 valid", cfg_err, 0);

    // Directed corners: tightest timing, then a busy poke
    run_test(16'hA5A5, 16'h5A5A, 1, 2, 1'b0, 100);
    run_test(16'h0001, 16'hFFFE, 1, 2, 1'b1, 200);
    run_test(16'h1234, 16'h4321, 7, 8, 1'b1, 300);
    run_test(16'hFFFF, 16'h0000, 2, 30, 1'b0, 400);

    // Reset in the middle of a run
    @(negedge clk);
    vec_a = 16'hBEEF; vec_b = 16'hCAFE; rated_cyc = 12'd3; slow_cyc = 12'd9; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    // R1 mid-run reset
    chk(!in_strobe && !out_strobe && !done && in_word == '0 && resp_word == '0,
        "R1 mid-run reset", {in_strobe, out_strobe, done}, 0);
    rst = 1'b0;
    repeat (15) @(negedge clk);
    chk(!in_strobe && !out_strobe, "R1 stays idle", {in_strobe, out_strobe}, 0);

    // Random runs
    for (int i = 0; i < 24; i++) begin
      int r, s;
      r = 1 + int'($urandom % 6);
      s = r + 1 + int'($urandom % 9);
      run_test(DW'($urandom), DW'($urandom), r, s, (i % 3) == 0, 1000 + i * 37);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule